// File: doc/BRIEF.md
# Tester Memory Access Controller

This controller sits between a narrow tester pin interface and the storage of a small three-unit datapath. An external tester uses it to preload a program and operands, let the datapath run once, and then read results back. The block owns the run phase (loading, running, inspecting), decodes which storage target a 16-bit word goes to, generates single-cycle write strobes, and multiplexes read data onto one 16-bit output.

There are five instruction memories, each 64 words deep. Slot 0 holds 7-bit words and slots 1 to 4 hold 16-bit words. There is also a 256-word data memory and a 16-entry register file. A target flag chooses between the instruction memories and the data side. A second flag chooses between the data memory and the register file. A one-hot slot select picks the instruction memory. Addresses outside a target's depth are refused by the controller, so no aliased write can occur.

During the run phase, the datapath's program counter is released and the three supply-control signals for the arithmetic, load/store and multiply-accumulate units are made visible. In the other two phases the program counter is held in reset, so every run fetches from address 0.

Top module: `memacc_ctrl`

## Requirements
- R1: After reset the phase is loading (code 0). `pc_rst_o` is 1, `run_o` is 0, all write strobes are 0, `dout_o` is 0 and `pwr_obs_o` is 0.
- R2: Phase codes are 0 loading, 1 running and 2 inspecting. The phase moves only when `mode_req_i` equals its successor (0 to 1, 1 to 2, 2 to 0), one clock edge after the request. Any other request, including code 3, leaves the phase unchanged.
- R3: In loading, a write request with target flag 0, exactly one bit set in `imem_sel_i` and address below 64 raises the matching `imem_we_o` bit in the same cycle. In that case `imem_addr_o` equals `addr_i[5:0]` and `wdata_o` equals `din_i`.
- R4: An instruction-memory write whose select is not one-hot, or whose address is 64 or more, raises no strobe and changes no word.
- R5: In loading, a write request with target flag 1 and bank flag 0 raises `dmem_we_o`, with `dmem_addr_o` equal to all 8 address bits.
- R6: In loading, a write request with target flag 1 and bank flag 1 raises `rf_we_o` only for addresses below 16, with `rf_addr_o` equal to `addr_i[3:0]`. Higher addresses write nothing.
- R7: No write strobe is raised outside the loading phase, or while `wr_en_i` is 0.
- R8: `run_o` is 1 and `pc_rst_o` is 0 exactly while the phase is running. Otherwise `pc_rst_o` is 1.
- R9: `pwr_obs_o` equals `pwr_ctl_i` while running and is 0 in the other phases.
- R10: While inspecting with target flag 1, `dout_o` presents on the next cycle the data-memory word (bank flag 0) or the register-file word (bank flag 1) at `addr_i`. A register-file address of 16 or more yields 0.
- R11: While inspecting with target flag 0, `dout_o` presents on the next cycle the selected instruction-memory word. Slot 0 is zero-extended from its 7 low bits. A non-one-hot select or an address of 64 or more yields 0.
- R12: At every clock edge taken outside the inspecting phase, `dout_o` is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_req_i | input | 2 | Requested phase code |
| wr_en_i | input | 1 | Write request for the current cycle |
| tgt_i | input | 1 | 0 instruction memories, 1 data side |
| dsel_i | input | 1 | Data side: 0 data memory, 1 register file |
| imem_sel_i | input | 5 | One-hot instruction memory slot select |
| addr_i | input | 8 | Word address |
| din_i | input | 16 | Write data from the tester |
| phase_o | output | 2 | Current phase code |
| pc_rst_o | output | 1 | Holds the datapath program counter in reset |
| run_o | output | 1 | Datapath run enable |
| imem_we_o | output | 5 | Instruction memory write strobes |
| imem_addr_o | output | 6 | Instruction memory address |
| dmem_we_o | output | 1 | Data memory write strobe |
| dmem_addr_o | output | 8 | Data memory address |
| rf_we_o | output | 1 | Register file write strobe |
| rf_addr_o | output | 4 | Register file address |
| wdata_o | output | 16 | Write data to all targets |
| imem_rdata_i | input | 80 | Read words of the five slots, slot k at bits 16k+15:16k |
| dmem_rdata_i | input | 16 | Data memory read word |
| rf_rdata_i | input | 16 | Register file read word |
| dout_o | output | 16 | Read-back data to the tester |
| pwr_ctl_i | input | 3 | Supply-control signals from the datapath |
| pwr_obs_o | output | 3 | Supply-control signals made visible while running |

## Verification
The assertions assume that the memories return the word at the presented address within the same cycle, and that reset is held low for at least one clock edge. They also assume that the tester changes inputs only between edges. The bench drives every input at the falling edge and models each memory as an asynchronous-read array written on the rising edge. Read-back checks therefore see data taken from the same address that the controller presents. Out-of-range and ignored writes are confirmed by reading the affected words back while inspecting.

// File: rtl/memacc_pkg.sv
package memacc_pkg;

  typedef enum logic [1:0] {
    PH_WRITE = 2'd0,
    PH_EXEC  = 2'd1,
    PH_TEST  = 2'd2
  } phase_t;

  // Fixed forward order of the run phases
  function automatic phase_t phase_succ(input phase_t p);
    case (p)
      PH_WRITE: return PH_EXEC;
      PH_EXEC:  return PH_TEST;
      default:  return PH_WRITE;
    endcase
  endfunction

  // Address lies inside a storage of the given depth
  function automatic logic fits(input int a, input int depth);
    return (a >= 0) && (a < depth);
  endfunction

endpackage

// File: rtl/memacc_phase_seq.sv
module memacc_phase_seq
  import memacc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_req,
  output phase_t     phase
);
  phase_t succ;
  logic   step;

  assign succ = phase_succ(phase);
  assign step = (mode_req == succ);

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_WRITE;
    else if (step) phase <= succ;
  end

  // R2: a phase change is always to the successor of the previous phase
  a_r2_forward_only: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != $past(phase)) |-> (phase == phase_succ($past(phase))));

  // R2: a request that is not the successor leaves the phase alone
  a_r2_hold_other: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req != phase_succ(phase)) |=> $stable(phase));
endmodule

// File: rtl/memacc_wr_decode.sv
module memacc_wr_decode
  import memacc_pkg::*;
#(
  parameter int AW         = 8,
  parameter int N_IMEM     = 5,
  parameter int IMEM_DEPTH = 64,
  parameter int RF_DEPTH   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_phase,
  input  logic              wr_en,
  input  logic              tgt,
  input  logic              dsel,
  input  logic [N_IMEM-1:0] sel,
  input  logic [AW-1:0]     addr,
  output logic [N_IMEM-1:0] imem_we,
  output logic              dmem_we,
  output logic              rf_we
);
  logic wr_go;
  logic imem_ok;
  logic rf_ok;

  assign wr_go   = wr_phase & wr_en;
  assign imem_ok = wr_go & ~tgt & $onehot(sel) & fits(32'(addr), IMEM_DEPTH);
  assign rf_ok   = fits(32'(addr), RF_DEPTH);

  for (genvar k = 0; k < N_IMEM; k++) begin : g_imem_we
    assign imem_we[k] = imem_ok & sel[k];
  end

  assign dmem_we = wr_go & tgt & ~dsel;
  assign rf_we   = wr_go & tgt & dsel & rf_ok;

  // R3: at most one storage is written per cycle
  a_r3_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({imem_we, dmem_we, rf_we}));

  // R4: an instruction memory strobe only for an in-range address
  a_r4_imem_range: assert property (@(posedge clk) disable iff (!rst_n)
    (|imem_we) |-> (32'(addr) < IMEM_DEPTH));

  // R6: a register file strobe only for an in-range address
  a_r6_rf_range: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (32'(addr) < RF_DEPTH));
endmodule

// File: rtl/memacc_rd_mux.sv
module memacc_rd_mux
  import memacc_pkg::*;
#(
  parameter int DW         = 16,
  parameter int AW         = 8,
  parameter int N_IMEM     = 5,
  parameter int IMEM_DEPTH = 64,
  parameter int IMEM0_W    = 7,
  parameter int RF_DEPTH   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 test_phase,
  input  logic                 tgt,
  input  logic                 dsel,
  input  logic [N_IMEM-1:0]    sel,
  input  logic [AW-1:0]        addr,
  input  logic [N_IMEM*DW-1:0] imem_rdata,
  input  logic [DW-1:0]        dmem_rdata,
  input  logic [DW-1:0]        rf_rdata,
  output logic [DW-1:0]        dout
);
  logic [DW-1:0] slot_word [N_IMEM];
  logic [DW-1:0] imem_pick;
  logic [DW-1:0] data_pick;
  logic [DW-1:0] rd_next;
  logic          imem_ok;

  for (genvar k = 0; k < N_IMEM; k++) begin : g_slot
    if (k == 0) begin : g_narrow
      assign slot_word[k] = {{(DW-IMEM0_W){1'b0}}, imem_rdata[IMEM0_W-1:0]};
    end else begin : g_wide
      assign slot_word[k] = imem_rdata[k*DW +: DW];
    end
  end

  assign imem_ok = $onehot(sel) & fits(32'(addr), IMEM_DEPTH);

  always_comb begin
    imem_pick = '0;
    for (int k = 0; k < N_IMEM; k++)
      if (sel[k]) imem_pick = imem_pick | slot_word[k];
    if (!imem_ok) imem_pick = '0;
  end

  always_comb begin
    if (dsel) data_pick = fits(32'(addr), RF_DEPTH) ? rf_rdata : '0;
    else      data_pick = dmem_rdata;
  end

  assign rd_next = tgt ? data_pick : imem_pick;

  always_ff @(posedge clk) begin
    if (!rst_n)          dout <= '0;
    else if (test_phase) dout <= rd_next;
    else                 dout <= '0;
  end

  // R12: output cleared after any edge outside inspection
  a_r12_dout_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !test_phase |=> (dout == '0));

  // R10: out-of-range register file read returns zero
  a_r10_rf_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (test_phase && tgt && dsel && (32'(addr) >= RF_DEPTH)) |=> (dout == '0));

  // R11: bad slot select reads zero
  a_r11_bad_sel_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (test_phase && !tgt && !$onehot(sel)) |=> (dout == '0));
endmodule

// File: rtl/memacc_ctrl.sv
module memacc_ctrl
  import memacc_pkg::*;
#(
  parameter int DW         = 16,
  parameter int AW         = 8,
  parameter int N_IMEM     = 5,
  parameter int IMEM_DEPTH = 64,
  parameter int IMEM0_W    = 7,
  parameter int RF_DEPTH   = 16,
  parameter int N_PWR      = 3,
  localparam int IMEM_AW   = $clog2(IMEM_DEPTH),
  localparam int RF_AW     = $clog2(RF_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode_req_i,
  input  logic                 wr_en_i,
  input  logic                 tgt_i,
  input  logic                 dsel_i,
  input  logic [N_IMEM-1:0]    imem_sel_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        din_i,
  output logic [1:0]           phase_o,
  output logic                 pc_rst_o,
  output logic                 run_o,
  output logic [N_IMEM-1:0]    imem_we_o,
  output logic [IMEM_AW-1:0]   imem_addr_o,
  output logic                 dmem_we_o,
  output logic [AW-1:0]        dmem_addr_o,
  output logic                 rf_we_o,
  output logic [RF_AW-1:0]     rf_addr_o,
  output logic [DW-1:0]        wdata_o,
  input  logic [N_IMEM*DW-1:0] imem_rdata_i,
  input  logic [DW-1:0]        dmem_rdata_i,
  input  logic [DW-1:0]        rf_rdata_i,
  output logic [DW-1:0]        dout_o,
  input  logic [N_PWR-1:0]     pwr_ctl_i,
  output logic [N_PWR-1:0]     pwr_obs_o
);
  phase_t phase;
  logic   in_write;
  logic   in_exec;
  logic   in_test;

  memacc_phase_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_req (mode_req_i),
    .phase    (phase)
  );

  assign in_write = (phase == PH_WRITE);
  assign in_exec  = (phase == PH_EXEC);
  assign in_test  = (phase == PH_TEST);

  memacc_wr_decode #(
    .AW(AW), .N_IMEM(N_IMEM), .IMEM_DEPTH(IMEM_DEPTH), .RF_DEPTH(RF_DEPTH)
  ) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_phase (in_write),
    .wr_en    (wr_en_i),
    .tgt      (tgt_i),
    .dsel     (dsel_i),
    .sel      (imem_sel_i),
    .addr     (addr_i),
    .imem_we  (imem_we_o),
    .dmem_we  (dmem_we_o),
    .rf_we    (rf_we_o)
  );

  memacc_rd_mux #(
    .DW(DW), .AW(AW), .N_IMEM(N_IMEM), .IMEM_DEPTH(IMEM_DEPTH),
    .IMEM0_W(IMEM0_W), .RF_DEPTH(RF_DEPTH)
  ) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_phase (in_test),
    .tgt        (tgt_i),
    .dsel       (dsel_i),
    .sel        (imem_sel_i),
    .addr       (addr_i),
    .imem_rdata (imem_rdata_i),
    .dmem_rdata (dmem_rdata_i),
    .rf_rdata   (rf_rdata_i),
    .dout       (dout_o)
  );

  assign phase_o     = phase;
  assign run_o       = in_exec;
  assign pc_rst_o    = ~in_exec;
  assign imem_addr_o = addr_i[IMEM_AW-1:0];
  assign dmem_addr_o = addr_i;
  assign rf_addr_o   = addr_i[RF_AW-1:0];
  assign wdata_o     = din_i;
  assign pwr_obs_o   = in_exec ? pwr_ctl_i : '0;

  // R7: no strobe leaves the block outside loading
  a_r7_quiet_outside_write: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_WRITE) |-> (imem_we_o == '0 && !dmem_we_o && !rf_we_o));

  // R8: running and program counter reset never overlap
  a_r8_pc_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_rst_o != run_o));

  // R9: supply controls hidden while not running
  a_r9_pwr_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o |-> (pwr_obs_o == '0));
endmodule

// File: tb/memacc_ctrl_test.sv
module memacc_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_req = 2'd0;
  logic        wr_en = 1'b0, tgt = 1'b0, dsel = 1'b0;
  logic [4:0]  sel = 5'd0;
  logic [7:0]  addr = 8'd0;
  logic [15:0] din = 16'd0;
  logic [1:0]  phase;
  logic        pc_rst, run;
  logic [4:0]  imem_we;
  logic [5:0]  imem_addr;
  logic        dmem_we;
  logic [7:0]  dmem_addr;
  logic        rf_we;
  logic [3:0]  rf_addr;
  logic [15:0] wdata;
  logic [79:0] imem_rdata;
  logic [15:0] dmem_rdata, rf_rdata, dout;
  logic [2:0]  pwr_ctl = 3'd0;
  logic [2:0]  pwr_obs;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  logic [15:0] im [5][64];
  logic [15:0] dm [256];
  logic [15:0] rf [16];
  logic [15:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  memacc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mode_req_i(mode_req), .wr_en_i(wr_en),
    .tgt_i(tgt), .dsel_i(dsel), .imem_sel_i(sel), .addr_i(addr), .din_i(din),
    .phase_o(phase), .pc_rst_o(pc_rst), .run_o(run), .imem_we_o(imem_we),
    .imem_addr_o(imem_addr), .dmem_we_o(dmem_we), .dmem_addr_o(dmem_addr),
    .rf_we_o(rf_we), .rf_addr_o(rf_addr), .wdata_o(wdata),
    .imem_rdata_i(imem_rdata), .dmem_rdata_i(dmem_rdata), .rf_rdata_i(rf_rdata),
    .dout_o(dout), .pwr_ctl_i(pwr_ctl), .pwr_obs_o(pwr_obs)
  );

  // Storage models: asynchronous read, write on the rising edge
  initial begin
    for (int k = 0; k < 5; k++)
      for (int a = 0; a < 64; a++) im[k][a] = 16'd0;
    for (int a = 0; a < 256; a++) dm[a] = 16'd0;
    for (int a = 0; a < 16; a++) rf[a] = 16'd0;
  end

  always @(posedge clk) begin
    for (int k = 0; k < 5; k++)
      if (imem_we[k]) im[k][imem_addr] <= wdata;
    if (dmem_we) dm[dmem_addr] <= wdata;
    if (rf_we) rf[rf_addr] <= wdata;
  end

  always_comb begin
    for (int k = 0; k < 5; k++)
      imem_rdata[k*16 +: 16] = (k == 0) ? {9'h1FF, im[0][imem_addr][6:0]} : im[k][imem_addr];
  end
  assign dmem_rdata = dm[dmem_addr];
  assign rf_rdata   = rf[rf_addr];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: one expected read-back per rising edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) chk(tag_q.pop_front(), 32'(dout), 32'(exp_q.pop_front()));
  end

  task automatic wr(input logic en, input logic t, input logic d, input logic [4:0] s,
                    input logic [7:0] a, input logic [15:0] v,
                    input logic [6:0] exp_we, input string req);
    @(negedge clk);
    wr_en = en; tgt = t; dsel = d; sel = s; addr = a; din = v;
    #1;
    chk(req, 32'({imem_we, dmem_we, rf_we}), 32'(exp_we));
    if (exp_we != 7'd0) begin
      chk(req, 32'(wdata), 32'(v));
      if (exp_we[6:2] != 5'd0) chk(req, 32'(imem_addr), 32'(a[5:0]));
      if (exp_we[1]) chk(req, 32'(dmem_addr), 32'(a));
      if (exp_we[0]) chk(req, 32'(rf_addr), 32'(a[3:0]));
    end
  endtask

  task automatic rd(input logic t, input logic d, input logic [4:0] s,
                    input logic [7:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    wr_en = 1'b0; tgt = t; dsel = d; sel = s; addr = a;
    exp_q.push_back(exp); tag_q.push_back(req);
  endtask

  task automatic go(input logic [1:0] m, input logic [1:0] exp_ph, input string req);
    @(negedge clk);
    mode_req = m;
    @(negedge clk);
    chk(req, 32'(phase), 32'(exp_ph));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pwr_ctl = 3'b111;
    #1;
    // R1 reset state
    chk("R1", 32'(phase), 32'd0);
    chk("R1", 32'(pc_rst), 32'd1);
    chk("R1", 32'(run), 32'd0);
    chk("R1", 32'({imem_we, dmem_we, rf_we}), 32'd0);
    chk("R1", 32'(dout), 32'd0);
    chk("R9", 32'(pwr_obs), 32'd0);

    // R3 each slot at its own address; bit order {imem_we[4:0], dmem, rf}
    wr(1, 0, 0, 5'b00001, 8'd10, 16'hFFF3, 7'b0000100, "R3");
    for (int k = 1; k < 5; k++)
      wr(1, 0, 0, 5'(1 << k), 8'(10 + k), 16'hA5C0 + 16'(k), 7'((1 << k) << 2), "R3");
    // R4 out-of-range address and bad select
    wr(1, 0, 0, 5'b00100, 8'd70, 16'h1234, 7'd0, "R4");
    wr(1, 0, 0, 5'b00011, 8'd20, 16'h5555, 7'd0, "R4");
    // R5 data memory
    wr(1, 1, 0, 5'd0, 8'd200, 16'hBEEF, 7'b0000010, "R5");
    wr(1, 1, 0, 5'd0, 8'd0,   16'h0F0F, 7'b0000010, "R5");
    wr(1, 1, 0, 5'd0, 8'd255, 16'h8001, 7'b0000010, "R5");
    // R6 register file
    wr(1, 1, 1, 5'd0, 8'd5,  16'h1357, 7'b0000001, "R6");
    wr(1, 1, 1, 5'd0, 8'd15, 16'h2468, 7'b0000001, "R6");
    wr(1, 1, 1, 5'd0, 8'd16, 16'h9999, 7'd0, "R6");
    // R7 no request, no strobe
    wr(0, 1, 0, 5'd0, 8'd1, 16'h7777, 7'd0, "R7");

    // R2 skipping ahead is ignored
    go(2'd2, 2'd0, "R2");
    go(2'd3, 2'd0, "R2");
    go(2'd1, 2'd1, "R2");
    pwr_ctl = 3'b101;
    #1;
    chk("R8", 32'({run, pc_rst}), 32'b10);
    chk("R9", 32'(pwr_obs), 32'b101);
    wr(1, 1, 0, 5'd0, 8'd2, 16'h4444, 7'd0, "R7");
    go(2'd0, 2'd1, "R2");
    go(2'd2, 2'd2, "R2");
    #1;
    chk("R8", 32'({run, pc_rst}), 32'b01);
    chk("R9", 32'(pwr_obs), 32'd0);
    wr(1, 1, 1, 5'd0, 8'd3, 16'h6666, 7'd0, "R7");

    // R10 data side read-back
    rd(1, 0, 5'd0, 8'd200, 16'hBEEF, "R10");
    rd(1, 0, 5'd0, 8'd0,   16'h0F0F, "R10");
    rd(1, 0, 5'd0, 8'd255, 16'h8001, "R10");
    rd(1, 1, 5'd0, 8'd5,   16'h1357, "R10");
    rd(1, 1, 5'd0, 8'd15,  16'h2468, "R10");
    rd(1, 1, 5'd0, 8'd20,  16'h0000, "R10");
    rd(1, 1, 5'd0, 8'd3,   16'h0000, "R7");
    rd(1, 0, 5'd0, 8'd1,   16'h0000, "R7");
    rd(1, 0, 5'd0, 8'd2,   16'h0000, "R7");
    rd(1, 1, 5'd0, 8'd0,   16'h0000, "R6");
    // R11 instruction memory read-back
    rd(0, 0, 5'b00001, 8'd10, 16'h0073, "R11");
    for (int k = 1; k < 5; k++)
      rd(0, 0, 5'(1 << k), 8'(10 + k), 16'hA5C0 + 16'(k), "R11");
    rd(0, 0, 5'b00100, 8'd70, 16'h0000, "R11");
    rd(0, 0, 5'b00000, 8'd11, 16'h0000, "R11");
    rd(0, 0, 5'b00100, 8'd6,  16'h0000, "R4");
    rd(0, 0, 5'b00001, 8'd20, 16'h0000, "R4");
    rd(0, 0, 5'b00010, 8'd20, 16'h0000, "R4");
    rd(1, 0, 5'd0, 8'd200, 16'hBEEF, "R10");
    @(negedge clk);
    go(2'd3, 2'd2, "R2");
    // R12 output clears once loading resumes
    go(2'd0, 2'd0, "R2");
    @(negedge clk);
    chk("R12", 32'(dout), 32'd0);
    chk("R8", 32'({run, pc_rst}), 32'b01);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule